// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block sits on the device side of a parallel NOR-style flash. It watches host bus writes (address, data byte and a one-clock write strobe) and recognises the six-write sector erase command. When the last write of that command arrives, it starts a timed acceptance window. During the window the host can name more sectors. Each named sector sets one bit of a sector-select bitmap and restarts the window.

When the window runs out, or when an erase suspend arrives, the bitmap is frozen and handed to an erase engine through a run level. The run level stays high until the engine reports completion. A foreign command written inside the window discards the queued sectors and returns the block to array-read mode. Once erasure runs, every command except suspend is ignored. An active-low asynchronous hardware reset stops an erase at once.

Top module: `flash_erase_seq`

## Requirements
- R1: While rst_ni is low, and at once when it falls, including in the middle of an erase: ready_o is 1, erase_run_o is 0, timer_expired_o is 0, suspend_o is 0 and sector_mask_o is all zero.
- R2: The command is accepted when six consecutive strobed writes carry 0xAA at address low bits 0x555, then 0x55 at 0x2AA, then 0x80 at 0x555, then 0xAA at 0x555, then 0x55 at 0x2AA, then 0x30 at any address. Only address bits [10:0] are compared. After the edge that captures the sixth write, ready_o is 0 and the bit of sector_mask_o indexed by address bits [ADDR_W-1:ADDR_W-SECT_W] is set.
- R3: A write that does not match the expected step returns the decoder to its first step. The remaining steps of that attempt are then not accepted, and ready_o stays 1.
- R4: While the window is open, a write with data 0x30 sets the bit of the sector named by its address and reloads the window to WIN_CYC clocks.
- R5: When no write arrives for WIN_CYC edges after the edge that captured the last accepted write, erase_run_o and timer_expired_o rise on that WIN_CYC-th edge, and sector_mask_o holds the queued set.
- R6: While the window is open, a write whose data is neither 0x30 nor 0xB0 clears sector_mask_o and sets ready_o. No erase follows.
- R7: While the window is open, a write with data 0xB0 ends the window on that edge. erase_run_o rises, and suspend_o is high for exactly one clock.
- R8: While erasing, writes other than 0xB0 leave sector_mask_o and erase_run_o unchanged. A 0xB0 write gives a one-clock suspend_o pulse, and erasing continues.
- R9: On the edge where erase_done_i is sampled high while erasing, ready_o returns to 1, and erase_run_o, timer_expired_o and sector_mask_o clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| we_i | input | 1 | Bus write strobe, one clock per write |
| addr_i | input | ADDR_W | Bus write address |
| data_i | input | 8 | Bus write data |
| erase_done_i | input | 1 | Erase engine finished |
| sector_mask_o | output | 2**SECT_W | Selected sectors |
| erase_run_o | output | 1 | Erase engine runs while high |
| timer_expired_o | output | 1 | Acceptance window has expired |
| ready_o | output | 1 | High in array-read mode, low while busy |
| suspend_o | output | 1 | One-clock erase suspend request |

## Verification
Every result is registered, so it appears on the edge that captures the stimulus. The bench drives on falling edges and reads at the next falling edge. The window expiry is due exactly WIN_CYC edges after the last accepted write. The bench checks run and expired both low one edge before that point and high on it, so an off-by-one error in the counter is caught. The suspend pulse is read on the first falling edge after the 0xB0 write and again one edge later. The asynchronous reset is checked one nanosecond after it falls, with no clock edge in between.

// File: rtl/flash_erase_pkg.sv
`timescale 1ns/1ps
package flash_erase_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WINDOW, ST_ERASE} seq_state_e;

  localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;
  localparam logic [7:0]  CMD_SUSP   = 8'hB0;
  localparam logic [10:0] ADR_UNLK_A = 11'h555;
  localparam logic [10:0] ADR_UNLK_B = 11'h2AA;
  localparam int          STEPS      = 6;
endpackage

// File: rtl/fes_unlock_match.sv
`timescale 1ns/1ps
module fes_unlock_match
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              hit_o
);
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic [10:0]       a_lo;
  logic              step_ok;

  assign a_lo = addr_i[10:0];

  always_comb begin
    unique case (step_q)
      STEP_W'(0): step_ok = (data_i == CMD_UNLK_A) && (a_lo == ADR_UNLK_A);
      STEP_W'(1): step_ok = (data_i == CMD_UNLK_B) && (a_lo == ADR_UNLK_B);
      STEP_W'(2): step_ok = (data_i == CMD_SETUP)  && (a_lo == ADR_UNLK_A);
      STEP_W'(3): step_ok = (data_i == CMD_UNLK_A) && (a_lo == ADR_UNLK_A);
      STEP_W'(4): step_ok = (data_i == CMD_UNLK_B) && (a_lo == ADR_UNLK_B);
      STEP_W'(5): step_ok = (data_i == CMD_SECTOR);
      default:    step_ok = 1'b0;
    endcase
  end

  assign hit_o = en_i && we_i && step_ok && (step_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        step_q <= '0;
    else if (!en_i)                     step_q <= '0;
    else if (we_i) begin
      if (step_ok && step_q != LAST)    step_q <= step_q + 1'b1;
      else                              step_q <= '0;
    end
  end
endmodule

// File: rtl/fes_window_timer.sv
`timescale 1ns/1ps
module fes_window_timer #(
  parameter int WIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CNT_W'(WIN_CYC - 1);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fes_sector_map.sv
`timescale 1ns/1ps
module fes_sector_map #(
  parameter int SECT_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 set_i,
  input  logic [SECT_W-1:0]    idx_i,
  output logic [2**SECT_W-1:0] mask_o
);
  localparam int NSECT = 2**SECT_W;

  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mask_o[g] <= 1'b0;
      else if (clr_i)                           mask_o[g] <= 1'b0;
      else if (set_i && idx_i == SECT_W'(g))    mask_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECT_W  = 3,
  parameter int WIN_CYC = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           data_i,
  input  logic                 erase_done_i,
  output logic [2**SECT_W-1:0] sector_mask_o,
  output logic                 erase_run_o,
  output logic                 timer_expired_o,
  output logic                 ready_o,
  output logic                 suspend_o
);
  localparam int NSECT = 2**SECT_W;

  seq_state_e        state_q, state_d;
  logic              seq_hit, win_zero;
  logic              tmr_load, map_set, map_clr, susp_d;
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];

  fes_unlock_match #(.ADDR_W(ADDR_W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_IDLE),
    .we_i   (we_i),
    .addr_i (addr_i),
    .data_i (data_i),
    .hit_o  (seq_hit)
  );

  fes_window_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .run_i  (state_q == ST_WINDOW),
    .zero_o (win_zero)
  );

  fes_sector_map #(.SECT_W(SECT_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (map_clr),
    .set_i  (map_set),
    .idx_i  (sect_idx),
    .mask_o (sector_mask_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    map_set  = 1'b0;
    map_clr  = 1'b0;
    susp_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (seq_hit) begin
        state_d  = ST_WINDOW;
        tmr_load = 1'b1;
        map_set  = 1'b1;
      end
      ST_WINDOW: begin
        if (we_i) begin
          if (data_i == CMD_SECTOR) begin
            tmr_load = 1'b1;
            map_set  = 1'b1;
          end else if (data_i == CMD_SUSP) begin
            state_d = ST_ERASE;
            susp_d  = 1'b1;
          end else begin
            state_d = ST_IDLE;
            map_clr = 1'b1;
          end
        end else if (win_zero) begin
          state_d = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (erase_done_i) begin
          state_d = ST_IDLE;
          map_clr = 1'b1;
        end else if (we_i && data_i == CMD_SUSP) begin
          susp_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        map_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      suspend_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      suspend_o <= susp_d;
    end
  end

  assign ready_o         = (state_q == ST_IDLE);
  assign erase_run_o     = (state_q == ST_ERASE);
  assign timer_expired_o = (state_q == ST_ERASE);
endmodule

// File: rtl/fes_checker.sv
`timescale 1ns/1ps
module fes_checker #(
  parameter int NSECT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             erase_done_i,
  input logic [NSECT-1:0] sector_mask_o,
  input logic             erase_run_o,
  input logic             timer_expired_o,
  input logic             ready_o,
  input logic             suspend_o
);
  AST_RUN_HAS_SECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_run_o |-> sector_mask_o != '0); // R5
  AST_RUN_FROM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_run_o) |-> !$past(ready_o)); // R5
  AST_EXPIRED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_expired_o |-> !ready_o); // R5
  AST_READY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sector_mask_o == '0); // R6
  AST_SUSPEND_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> erase_run_o); // R7
  AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_run_o && $past(erase_run_o)) |-> $stable(sector_mask_o)); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_run_o && erase_done_i) |=> (ready_o && sector_mask_o == '0)); // R9
endmodule

bind flash_erase_seq fes_checker #(.NSECT(NSECT)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .erase_done_i    (erase_done_i),
  .sector_mask_o   (sector_mask_o),
  .erase_run_o     (erase_run_o),
  .timer_expired_o (timer_expired_o),
  .ready_o         (ready_o),
  .suspend_o       (suspend_o)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;
  localparam int AW = 12;
  localparam int SW = 3;
  localparam int WIN = 16;
  localparam int NS = 2**SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic          done = 1'b0;
  logic [NS-1:0] mask;
  logic          run, expd, rdy, susp;
  int            n_chk = 0;
  int            n_err = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .data_i(data),
    .erase_done_i(done), .sector_mask_o(mask), .erase_run_o(run),
    .timer_expired_o(expd), .ready_o(rdy), .suspend_o(susp)
  );

  function automatic logic [AW-1:0] sa(int s);
    return AW'(s) << (AW - SW);
  endfunction

  function automatic logic [7:0] foreign_cmd(logic [7:0] r);
    return (r == 8'h30 || r == 8'hB0) ? 8'hF0 : r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic state_chk(string req, logic [NS-1:0] m, logic r, logic x, logic y);
    chk(req, "mask", 32'(mask), 32'(m));
    chk(req, "run", 32'(run), 32'(r));
    chk(req, "expired", 32'(expd), 32'(x));
    chk(req, "ready", 32'(rdy), 32'(y));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic full_seq(int s);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sa(s), 8'h30);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NS-1:0] em;
    void'($urandom(32'd1234));
    #12 state_chk("R1", '0, 0, 0, 1);
    chk("R1", "suspend", 32'(susp), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2, R4, R5, R8, R9
    full_seq(5);
    state_chk("R2", 8'h20, 0, 0, 0);
    idle(3); wr(sa(2), 8'h30);
    state_chk("R4", 8'h24, 0, 0, 0);
    idle(WIN - 1);
    state_chk("R4", 8'h24, 0, 0, 0);
    idle(1);
    state_chk("R5", 8'h24, 1, 1, 0);
    wr(sa(7), 8'h30); wr(sa(1), 8'hF0);
    state_chk("R8", 8'h24, 1, 1, 0);
    idle(2); pulse_done();
    state_chk("R9", '0, 0, 0, 1);

    // R3: broken sequence
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sa(3), 8'h30);
    state_chk("R3", '0, 0, 0, 1);
    wr(12'h555, 8'hAA); wr(12'h2A0, 8'h55); wr(12'h555, 8'h80);
    state_chk("R3", '0, 0, 0, 1);
    full_seq(1);
    state_chk("R3", 8'h02, 0, 0, 0);

    // R6 abort
    wr(sa(4), 8'hF0);
    state_chk("R6", '0, 0, 0, 1);
    idle(WIN + 2);
    state_chk("R6", '0, 0, 0, 1);

    // R7 suspend in window, R8 suspend during erase
    full_seq(6);
    wr(sa(0), 8'hB0);
    state_chk("R7", 8'h40, 1, 1, 0);
    chk("R7", "suspend", 32'(susp), 1);
    idle(1);
    chk("R7", "suspend", 32'(susp), 0);
    wr(sa(2), 8'hB0);
    chk("R8", "suspend", 32'(susp), 1);
    state_chk("R8", 8'h40, 1, 1, 0);
    idle(1);
    chk("R8", "suspend", 32'(susp), 0);

    // R1 async reset mid-erase
    #1 rst_n = 1'b0;
    #1 state_chk("R1", '0, 0, 0, 1);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // random
    for (int it = 0; it < 40; it++) begin
      int s0, k;
      s0 = int'($urandom_range(NS - 1));
      em = NS'(1) << s0;
      full_seq(s0);
      state_chk("R2", em, 0, 0, 0);
      k = int'($urandom_range(3));
      for (int j = 0; j < k; j++) begin
        int s;
        s = int'($urandom_range(NS - 1));
        idle(int'($urandom_range(WIN - 1)));
        wr(sa(s), 8'h30);
        em |= NS'(1) << s;
        state_chk("R4", em, 0, 0, 0);
      end
      if ($urandom_range(3) == 0) begin
        idle(int'($urandom_range(WIN - 1)));
        wr(sa(0), foreign_cmd(8'($urandom)));
        state_chk("R6", '0, 0, 0, 1);
      end else begin
        idle(WIN - 1);
        state_chk("R5", em, 0, 0, 0);
        idle(1);
        state_chk("R5", em, 1, 1, 0);
        for (int j = 0; j < int'($urandom_range(2)); j++)
          wr(AW'($urandom), foreign_cmd(8'($urandom)));
        state_chk("R8", em, 1, 1, 0);
        idle(int'($urandom_range(4)));
        pulse_done();
        state_chk("R9", '0, 0, 0, 1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule